// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Strobe

This block takes a signed five-digit conversion result and drives a time-multiplexed display along with a host-side latch. It holds one digit-select line high at a time, stepping from the most significant position down to the least significant one, and repeats the scan for as long as it runs. While a select line is high, the 4-bit BCD code of that digit is present on the BCD bus. The most significant position is a half digit that holds only 0 or 1, so the readable span is 0 to 19999 in magnitude.

On each end-of-conversion event the block copies the result into an internal holding register and restarts the scan at the top digit. During that first pass it places one short active-low strobe in every digit slot, which a host can use to latch the five digits in order. Later passes refresh the display without strobes. If the over-range flag is set when the strobed pass finishes, every select goes dark until the next deintegrate-start event. That event restarts the scan at the top digit with no strobes.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After synchronous reset, and until the first end-of-conversion or deintegrate-start event, all selects and BCD bits are 0 and the strobe is high (released).
- R2: While scanning, exactly one select is high. The order is bit NUM_DIGITS-1 (most significant), then one bit lower each slot down to bit 0, then the scan wraps back to the top bit.
- R3: Each select stays high for SLOT_LEN (200) cycles. The first top-digit slot after an end-of-conversion or deintegrate-start event lasts SLOT_LEN+1 (201) cycles. The first select appears in the cycle after the event is sampled.
- R4: The BCD bus carries the held code of the selected digit, with bit 3 weighted 8 and bit 0 weighted 1. For the top half digit, bits 3..1 are 0 and bit 0 holds its value. On the digit input, the digit at position k occupies bits 4k+3..4k, with k=0 being the least significant digit.
- R5: Result digits are captured only on an end-of-conversion event. Later changes on the digit inputs do not change the BCD bus until the next such event.
- R6: In the first pass after an end-of-conversion event, the strobe goes low in the 101st cycle of each of the five slots. This gives five strobes, top digit first.
- R7: The strobe pulse lasts half a clock period. It goes low in the second half of its cycle and is high in the first half of every cycle.
- R8: After the strobed pass, and after any deintegrate-start restart, scanning continues with no strobes.
- R9: The over-range flag is sampled in the last cycle of the strobed pass. If it is set, all selects and BCD bits are 0 from then until a deintegrate-start event. Scanning then resumes at the top digit with a 201-cycle slot.
- R10: When end-of-conversion and deintegrate-start fall in the same cycle, end-of-conversion wins: the data is captured and a strobed pass starts.
- R11: An end-of-conversion event in the middle of a scan restarts the scan at the top digit with a 201-cycle slot and a fresh strobed pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe uses both edges |
| rst | input | 1 | Synchronous reset, active high |
| eoc_i | input | 1 | End-of-conversion event, one cycle |
| deint_i | input | 1 | Deintegrate-start event, one cycle |
| over_range_i | input | 1 | Over-range flag of the finished conversion |
| msd_i | input | 1 | Half-digit (top) value, 0 or 1 |
| digits_i | input | 4*(NUM_DIGITS-1) | Lower BCD digits, digit k at bits 4k+3..4k |
| digit_sel_o | output | NUM_DIGITS | One-hot digit selects, top bit = most significant |
| bcd_o | output | 4 | BCD code of the selected digit |
| strobe_n_o | output | 1 | Active-low half-cycle latch strobe |

## Verification
Two of the block's functions can act in the same cycle. The first case is an end-of-conversion event arriving together with a deintegrate-start event. Both restart the scan, but only one of them may start a strobed pass, and the bench checks that strobes and freshly captured data follow in the very next slot. The second case is the over-range decision at the last cycle of the strobed pass, where the scan wrap and the blanking start coincide. The bench holds the flag high across that boundary and expects the selects to go dark on the cycle in which the top digit would otherwise return. A behavioural cycle model, built from elapsed-time arithmetic rather than counters, judges every cycle. It samples the strobe once in each half of the clock.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_scan_hold.sv
module bcd_scan_hold
   import bcd_scan_pkg::*;
#(
   parameter int NUM_DIGITS = 5,
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
   localparam int LOW_W = BCD_W * (NUM_DIGITS - 1)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             msd_i,
   input  logic [LOW_W-1:0] low_i,
   input  logic             en_i,
   input  logic [IDX_W-1:0] idx_i,
   output bcd_t             bcd_o
);
   logic             msd_q;
   logic [LOW_W-1:0] low_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         msd_q <= 1'b0;
         low_q <= '0;
      end else if (load_i) begin
         msd_q <= msd_i;
         low_q <= low_i;
      end
   end

   always_comb begin
      bcd_o = '0;
      if (en_i) begin
         if (idx_i == IDX_W'(NUM_DIGITS - 1)) begin
            bcd_o = {{(BCD_W-1){1'b0}}, msd_q};
         end else begin
            for (int k = 0; k < NUM_DIGITS - 1; k++) begin
               if (idx_i == IDX_W'(k)) bcd_o = low_q[k*BCD_W +: BCD_W];
            end
         end
      end
   end

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> ($stable(low_q) && $stable(msd_q)));
endmodule

// File: rtl/bcd_scan_timer.sv
module bcd_scan_timer #(
   parameter int NUM_DIGITS = 5,
   parameter int SLOT_LEN   = 200,
   parameter int STROBE_AT  = 101,
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
   localparam int CNT_W = $clog2(SLOT_LEN + 1)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             eoc_i,
   input  logic             deint_i,
   input  logic             blank_i,
   output logic             run_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             seq_done_o,
   output logic             strobe_req_o
);
   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             long_q;
   logic             strb_q;
   logic             slot_end;

   assign slot_end     = cnt_q == (CNT_W'(SLOT_LEN - 1) + CNT_W'(long_q));
   assign run_o        = active_q && !blank_i;
   assign idx_o        = idx_q;
   assign seq_done_o   = run_o && strb_q && slot_end && (idx_q == '0);
   assign strobe_req_o = run_o && strb_q && (cnt_q == CNT_W'(STROBE_AT - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         idx_q    <= IDX_W'(NUM_DIGITS - 1);
         cnt_q    <= '0;
         long_q   <= 1'b0;
         strb_q   <= 1'b0;
      end else if (eoc_i || deint_i) begin
         active_q <= 1'b1;
         idx_q    <= IDX_W'(NUM_DIGITS - 1);
         cnt_q    <= '0;
         long_q   <= 1'b1;
         strb_q   <= eoc_i;
      end else if (run_o) begin
         if (slot_end) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
            if (idx_q == '0) begin
               idx_q  <= IDX_W'(NUM_DIGITS - 1);
               strb_q <= 1'b0;
            end else begin
               idx_q <= idx_q - 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(SLOT_LEN));
   // R3
   long_first_chk: assert property (@(posedge clk) disable iff (rst)
      (long_q && cnt_q != '0) |-> (idx_q == IDX_W'(NUM_DIGITS - 1)));
endmodule

// File: rtl/bcd_scan_blank.sv
module bcd_scan_blank (
   input  logic clk,
   input  logic rst,
   input  logic eoc_i,
   input  logic deint_i,
   input  logic seq_done_i,
   input  logic over_range_i,
   output logic blank_o
);
   always_ff @(posedge clk) begin
      if (rst)                           blank_o <= 1'b0;
      else if (eoc_i || deint_i)         blank_o <= 1'b0;
      else if (seq_done_i && over_range_i) blank_o <= 1'b1;
   end

   // R9
   blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (blank_o && !eoc_i && !deint_i) |=> blank_o);
endmodule

// File: rtl/bcd_scan_strobe.sv
module bcd_scan_strobe #(
   parameter bit HALF_CLK = 1'b1
)(
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   output logic strobe_n_o
);
   generate
      if (HALF_CLK) begin : g_half
         logic fall_q;
         always_ff @(negedge clk) begin
            if (rst) fall_q <= 1'b0;
            else     fall_q <= req_i;
         end
         assign strobe_n_o = !(req_i && fall_q);
      end else begin : g_full
         assign strobe_n_o = !req_i;
      end
   endgenerate
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
   import bcd_scan_pkg::*;
#(
   parameter int NUM_DIGITS = 5,
   parameter int SLOT_LEN   = 200,
   parameter int STROBE_AT  = 101,
   parameter bit HALF_CLK   = 1'b1,
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
   localparam int LOW_W = BCD_W * (NUM_DIGITS - 1)
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  eoc_i,
   input  logic                  deint_i,
   input  logic                  over_range_i,
   input  logic                  msd_i,
   input  logic [LOW_W-1:0]      digits_i,
   output logic [NUM_DIGITS-1:0] digit_sel_o,
   output logic [BCD_W-1:0]      bcd_o,
   output logic                  strobe_n_o
);
   localparam logic [NUM_DIGITS-1:0] TOP_HOT = NUM_DIGITS'(1) << (NUM_DIGITS - 1);
   localparam logic [NUM_DIGITS-1:0] BOT_HOT = NUM_DIGITS'(1);

   generate
      if (NUM_DIGITS < 2) begin : g_bad_n
         $error("NUM_DIGITS must be at least 2");
      end
      if (STROBE_AT < 1 || STROBE_AT > SLOT_LEN) begin : g_bad_strobe
         $error("STROBE_AT must fall inside a slot");
      end
   endgenerate

   logic             run;
   logic [IDX_W-1:0] idx;
   logic             seq_done;
   logic             strobe_req;
   logic             blank;
   bcd_t             bcd;

   bcd_scan_timer #(.NUM_DIGITS(NUM_DIGITS), .SLOT_LEN(SLOT_LEN), .STROBE_AT(STROBE_AT)) u_timer (
      .clk(clk), .rst(rst), .eoc_i(eoc_i), .deint_i(deint_i), .blank_i(blank),
      .run_o(run), .idx_o(idx), .seq_done_o(seq_done), .strobe_req_o(strobe_req));

   bcd_scan_blank u_blank (
      .clk(clk), .rst(rst), .eoc_i(eoc_i), .deint_i(deint_i),
      .seq_done_i(seq_done), .over_range_i(over_range_i), .blank_o(blank));

   bcd_scan_hold #(.NUM_DIGITS(NUM_DIGITS)) u_hold (
      .clk(clk), .rst(rst), .load_i(eoc_i), .msd_i(msd_i), .low_i(digits_i),
      .en_i(run), .idx_i(idx), .bcd_o(bcd));

   bcd_scan_strobe #(.HALF_CLK(HALF_CLK)) u_strobe (
      .clk(clk), .rst(rst), .req_i(strobe_req), .strobe_n_o(strobe_n_o));

   genvar g;
   generate
      for (g = 0; g < NUM_DIGITS; g++) begin : g_sel
         assign digit_sel_o[g] = run && (idx == IDX_W'(g));
      end
   endgenerate
   assign bcd_o = bcd;

   // R2
   scan_order_chk: assert property (@(posedge clk) disable iff (rst)
      (digit_sel_o != '0) |=> ((digit_sel_o == '0) || (digit_sel_o == $past(digit_sel_o))
         || (digit_sel_o == ($past(digit_sel_o) >> 1))
         || (digit_sel_o == TOP_HOT && $past(digit_sel_o) == BOT_HOT)
         || $past(eoc_i) || $past(deint_i)));
   // R9
   blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
      blank |-> (digit_sel_o == '0 && bcd_o == '0));
   // R6
   strobe_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
      strobe_req |-> $onehot(digit_sel_o));
   // R4
   msd_half_chk: assert property (@(posedge clk) disable iff (rst)
      digit_sel_o[NUM_DIGITS-1] |-> (bcd_o[BCD_W-1:1] == '0));
endmodule

// File: tb/test_bcd_digit_scanner.sv
module test_bcd_digit_scanner;
   localparam int N     = 5;
   localparam int SLOT  = 200;
   localparam int STRAT = 101;
   localparam int L0    = SLOT + 1;
   localparam int TOT   = L0 + (N - 1) * SLOT;

   logic clk = 1'b0;
   logic rst = 1'b1, eoc = 1'b0, deint = 1'b0, ovr = 1'b0, msd = 1'b0;
   logic [(N-1)*4-1:0] low = '0;
   logic [N-1:0] sel;
   logic [3:0]   bcd;
   logic         strobe_n;

   always #5 clk = ~clk;

   bcd_digit_scanner i_bcd_digit_scanner (
      .clk(clk), .rst(rst), .eoc_i(eoc), .deint_i(deint), .over_range_i(ovr),
      .msd_i(msd), .digits_i(low), .digit_sel_o(sel), .bcd_o(bcd), .strobe_n_o(strobe_n));

   int errors = 0, checks = 0;
   string phase = "R1";
   bit done = 0;

   int t;
   bit run, srun, mblank;
   int cap[N];

   task automatic chk(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", phase, tag, act, expv, $time);
      end
   endtask

   function automatic int cur_idx();
      if (t < L0) return N - 1;
      return N - 1 - ((((t - L0) / SLOT) + 1) % N);
   endfunction

   function automatic int cur_pos();
      if (t < L0) return t;
      return (t - L0) % SLOT;
   endfunction

   always @(posedge clk) begin
      int esel, ebcd, estr;
      if (rst) begin
         run = 0; srun = 0; mblank = 0; t = 0;
      end else if (eoc) begin
         run = 1; srun = 1; mblank = 0; t = 0;
         cap[N-1] = int'(msd);
         for (int k = 0; k < N - 1; k++) cap[k] = int'(low[4*k +: 4]);
      end else if (deint) begin
         run = 1; srun = 0; mblank = 0; t = 0;
      end else if (run && !mblank) begin
         t++;
         if (srun && t == TOT) begin
            srun = 0;
            if (ovr) mblank = 1;
         end
      end
      esel = 0; ebcd = 0; estr = 1;
      if (run && !mblank) begin
         esel = 1 << cur_idx();
         ebcd = cap[cur_idx()];
         if (srun && cur_pos() == STRAT - 1) estr = 0;
      end
      #3;
      chk("R2 R3 R9 select", int'(sel), esel);
      chk("R4 bcd", int'(bcd), ebcd);
      chk("R7 strobe first half", int'(strobe_n), 1);
      #4;
      chk("R6 R8 strobe second half", int'(strobe_n), estr);
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse_eoc();
      eoc = 1'b1; step(1); eoc = 1'b0;
   endtask

   task automatic pulse_deint();
      deint = 1'b1; step(1); deint = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      phase = "R1";
      step(4);
      rst = 1'b0;
      step(30);
      phase = "R2";
      msd = 1'b1; low = {4'd9, 4'd8, 4'd7, 4'd6};
      pulse_eoc();
      step(2500);
      phase = "R5";
      msd = 1'b0; low = {4'd1, 4'd2, 4'd3, 4'd4};
      step(1500);
      pulse_eoc();
      step(1200);
      phase = "R11";
      step(300);
      low = {4'd5, 4'd0, 4'd9, 4'd3};
      pulse_eoc();
      step(1100);
      phase = "R9";
      ovr = 1'b1; msd = 1'b1;
      pulse_eoc();
      step(1400);
      ovr = 1'b0;
      step(50);
      pulse_deint();
      step(700);
      phase = "R10";
      low = {4'd2, 4'd4, 4'd6, 4'd8};
      eoc = 1'b1; deint = 1'b1;
      step(1);
      eoc = 1'b0; deint = 1'b0;
      step(1100);
      phase = "R8";
      pulse_deint();
      step(1300);
      finish_run();
   end
endmodule